// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block refills one cache line from an external bus after a cache miss. When the cache controller reports a miss, the block issues a single wrapping burst request that starts at the word that missed. Beats come back in wrapping order. Each beat is stored in a line-wide buffer, and a per-word arrival bit is set for it. The first beat is the word that missed. It goes straight back to the processor, together with an abort flag when that beat carried a bus error, so the pipeline can continue while the rest of the line is still arriving.

While the fill runs, the processor may issue further reads through the same read port. A read to the line being filled is answered from the buffer once its word has arrived, and stalls until then. A read to any other line stalls until the fill finishes. Outside a fill, it is answered with a miss response so that the controller takes it elsewhere. When all beats of a fill have landed without error, the whole line is written into the cache RAM in a single-cycle write. An error on any beat cancels that write and invalidates the buffer, so no later read sees partial data. Only an error on the first beat aborts the processor.

Addresses at the miss and read inputs are word addresses. The low `log2(WORDS)` bits select the word within the line, and the bits above them are the line tag. The default line holds 8 words of 32 bits. WORDS must be a power of two.

Top module: `line_fill_buf`

## Requirements
- R1: A miss with `miss_valid_i` high is accepted only when no fill is in progress. In the cycle after acceptance, `bus_req_o` is high for one cycle and `bus_addr_o` holds the byte address of the missed word (`{miss_addr_i, 2'b00}`). A miss presented during a fill produces no `bus_req_o` and does not disturb the running fill.
- R2: Beat k of a fill (k = 0..7) carries line word (c + k) mod 8, where c = `miss_addr_i[2:0]`. On the cache write, word i sits at `cw_data_o[32*i+31:32*i]`.
- R3: The cycle after the first beat is taken, `rd_valid_o` is high for one cycle and `rd_data_o` equals that beat's data. No other beat needs to have arrived.
- R4: The critical-word response has `rd_abort_o` high exactly when the first beat had `beat_err_i` high. `rd_abort_o` is never high without `rd_valid_o`.
- R5: A bus error on any beat other than the first never raises `rd_abort_o`.
- R6: During a fill, a read (`rd_req_i` held high) to the line being filled whose word has already arrived is answered in the cycle after it is taken. The answer has `rd_valid_o` high, the stored word on `rd_data_o`, and `rd_abort_o` low.
- R7: A read to a word of the filling line that has not yet arrived stalls. It is answered on the second cycle after the cycle in which that word's beat is taken.
- R8: A read to a different line stalls while a fill is in progress. Once no fill is in progress, it gets `rd_miss_o` high for one cycle. `rd_valid_o` and `rd_miss_o` are never high together.
- R9: The cycle after the last beat of an error-free fill, `cw_en_o` is high for exactly one cycle. `cw_addr_o` then holds the line's byte address (low 5 bits zero) and `cw_data_o` holds the full line.
- R10: If any beat of a fill reports an error, `cw_en_o` stays low for that fill.
- R11: After an error beat, reads to that line are never answered with `rd_valid_o`. They stall until the fill ends and then get `rd_miss_o`.
- R12: After an error-free fill completes, reads to that line are still answered from the buffer until the next miss is accepted.
- R13: After reset, every output is low. A read before any fill gets `rd_miss_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request strobe |
| miss_addr_i | input | 30 | Word address of the missed word |
| bus_req_o | output | 1 | One-cycle wrapping burst request |
| bus_addr_o | output | 32 | Byte address of the first word to fetch |
| beat_valid_i | input | 1 | Bus beat present |
| beat_data_i | input | 32 | Beat data |
| beat_err_i | input | 1 | Bus error on this beat |
| rd_req_i | input | 1 | Processor read, held until answered |
| rd_addr_i | input | 30 | Word address of the read |
| rd_valid_o | output | 1 | Read data returned |
| rd_data_o | output | 32 | Returned word |
| rd_abort_o | output | 1 | Critical word had a bus error |
| rd_miss_o | output | 1 | Read not held in the buffer |
| cw_en_o | output | 1 | Cache RAM line write strobe |
| cw_addr_o | output | 32 | Byte address of the written line |
| cw_data_o | output | 256 | Line data, word i at bits 32i+31:32i |

## Verification
Fills are run with the critical word at index 5, 0, 2, 7 and 3, so the wrap point falls at different positions and a fetch that starts at word 0 would put data in the wrong slot. Beats come both back to back and with gaps. With gaps, streaming reads can be issued before and after their word lands, which separates a read served early, a stall, and a response at the wrong cycle. An error on a middle beat is compared against an error on the critical beat, which separates a silently absorbed error from an abort. In both cases the cache write must be suppressed. A read to a foreign line during a fill, a read to the line after an error, and a read to the line after a clean fill show whether the block stalls, misses or serves from the buffer in each case.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef struct packed {
    logic valid;
    logic abort;
    logic miss;
  } rsp_flags_t;
endpackage

// File: rtl/lfb_beat_ctr.sv
module lfb_beat_ctr #(
  parameter int WORDS = 8,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] crit_idx_i,
  input  logic          beat_i,
  output logic [IW-1:0] idx_o,
  output logic          first_o,
  output logic          last_o
);
  logic [IW-1:0] base_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      base_q <= crit_idx_i;
      cnt_q  <= '0;
    end else if (beat_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // power-of-two line: sum wraps modulo WORDS
  assign idx_o   = base_q + cnt_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == IW'(WORDS - 1));

  assert_first_is_crit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (idx_o == $past(crit_idx_i)))
    else $error("first beat slot differs from critical index");
endmodule

// File: rtl/lfb_word_store.sv
module lfb_word_store #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int IW = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                wr_i,
  input  logic [IW-1:0]       wr_idx_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [WORDS-1:0]    arrived_o,
  output logic [WORDS*DW-1:0] line_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic          arr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        arr_q  <= 1'b0;
        data_q <= '0;
      end else if (clear_i) begin
        arr_q <= 1'b0;
      end else if (wr_i && wr_idx_i == IW'(w)) begin
        arr_q  <= 1'b1;
        data_q <= wr_data_i;
      end
    end

    assign arrived_o[w]           = arr_q;
    assign line_o[w*DW +: DW]     = data_q;
  end

  assert_slot_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i) |-> !arrived_o[wr_idx_i])
    else $error("line slot written twice in one fill");
endmodule

// File: rtl/lfb_rd_port.sv
module lfb_rd_port #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int TAG_W = 25,
  localparam int IW = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_req_i,
  input  logic [TAG_W-1:0]    rd_tag_i,
  input  logic [IW-1:0]       rd_widx_i,
  input  logic                crit_pend_i,
  input  logic                fill_i,
  input  logic                buf_valid_i,
  input  logic [TAG_W-1:0]    buf_tag_i,
  input  logic [WORDS-1:0]    arrived_i,
  input  logic [WORDS*DW-1:0] line_i,
  input  logic                crit_fire_i,
  input  logic [DW-1:0]       crit_data_i,
  input  logic                crit_err_i,
  output logic                rd_valid_o,
  output logic [DW-1:0]       rd_data_o,
  output logic                rd_abort_o,
  output logic                rd_miss_o
);
  import lfb_pkg::*;

  rsp_flags_t    rsp_q;
  logic [DW-1:0] data_q;
  logic          take, hit, serve;

  // one response per held request: skip the cycle the answer is visible
  assign take  = rd_req_i && !rsp_q.valid && !rsp_q.miss && !crit_pend_i;
  assign hit   = buf_valid_i && (rd_tag_i == buf_tag_i);
  assign serve = take && hit && arrived_i[rd_widx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q  <= '0;
      data_q <= '0;
    end else begin
      rsp_q.valid <= crit_fire_i || serve;
      rsp_q.abort <= crit_fire_i && crit_err_i;
      rsp_q.miss  <= take && !hit && !fill_i;
      if (crit_fire_i)  data_q <= crit_data_i;
      else if (serve)   data_q <= line_i[rd_widx_i*DW +: DW];
    end
  end

  assign rd_valid_o = rsp_q.valid;
  assign rd_abort_o = rsp_q.abort;
  assign rd_miss_o  = rsp_q.miss;
  assign rd_data_o  = data_q;

  assert_abort_with_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_abort_o |-> rd_valid_o)
    else $error("abort without returned data");

  assert_resp_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && rd_miss_o))
    else $error("data and miss response together");

  assert_no_miss_in_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !crit_fire_i) |=> !rd_miss_o)
    else $error("miss response while a fill runs");
endmodule

// File: rtl/line_fill_buf.sv
module line_fill_buf #(
  parameter int ADDR_W = 32,
  parameter int DW     = 32,
  parameter int WORDS  = 8,
  localparam int IW    = $clog2(WORDS),
  localparam int BO    = $clog2(DW / 8),
  localparam int WA_W  = ADDR_W - BO,
  localparam int OFF   = IW + BO,
  localparam int TAG_W = WA_W - IW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                miss_valid_i,
  input  logic [WA_W-1:0]     miss_addr_i,
  output logic                bus_req_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  input  logic                beat_valid_i,
  input  logic [DW-1:0]       beat_data_i,
  input  logic                beat_err_i,
  input  logic                rd_req_i,
  input  logic [WA_W-1:0]     rd_addr_i,
  output logic                rd_valid_o,
  output logic [DW-1:0]       rd_data_o,
  output logic                rd_abort_o,
  output logic                rd_miss_o,
  output logic                cw_en_o,
  output logic [ADDR_W-1:0]   cw_addr_o,
  output logic [WORDS*DW-1:0] cw_data_o
);
  logic             fill_q, crit_pend_q, buf_valid_q, err_q;
  logic [TAG_W-1:0] tag_q;
  logic             accept, beat;
  logic [IW-1:0]    beat_idx;
  logic             beat_first, beat_last;
  logic [WORDS-1:0] arrived;

  assign accept = miss_valid_i && !fill_q;
  assign beat   = beat_valid_i && fill_q;

  lfb_beat_ctr #(.WORDS(WORDS)) i_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .crit_idx_i (miss_addr_i[IW-1:0]),
    .beat_i     (beat),
    .idx_o      (beat_idx),
    .first_o    (beat_first),
    .last_o     (beat_last)
  );

  lfb_word_store #(.WORDS(WORDS), .DW(DW)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .wr_i      (beat),
    .wr_idx_i  (beat_idx),
    .wr_data_i (beat_data_i),
    .arrived_o (arrived),
    .line_o    (cw_data_o)
  );

  lfb_rd_port #(.WORDS(WORDS), .DW(DW), .TAG_W(TAG_W)) i_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req_i),
    .rd_tag_i    (rd_addr_i[WA_W-1:IW]),
    .rd_widx_i   (rd_addr_i[IW-1:0]),
    .crit_pend_i (crit_pend_q),
    .fill_i      (fill_q),
    .buf_valid_i (buf_valid_q),
    .buf_tag_i   (tag_q),
    .arrived_i   (arrived),
    .line_i      (cw_data_o),
    .crit_fire_i (beat && beat_first),
    .crit_data_i (beat_data_i),
    .crit_err_i  (beat_err_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .rd_abort_o  (rd_abort_o),
    .rd_miss_o   (rd_miss_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q      <= 1'b0;
      crit_pend_q <= 1'b0;
      buf_valid_q <= 1'b0;
      err_q       <= 1'b0;
      tag_q       <= '0;
      bus_req_o   <= 1'b0;
      bus_addr_o  <= '0;
      cw_en_o     <= 1'b0;
    end else begin
      bus_req_o <= accept;
      cw_en_o   <= beat && beat_last && !err_q && !beat_err_i;
      if (accept) begin
        bus_addr_o  <= {miss_addr_i, {BO{1'b0}}};
        fill_q      <= 1'b1;
        crit_pend_q <= 1'b1;
        buf_valid_q <= 1'b1;
        err_q       <= 1'b0;
        tag_q       <= miss_addr_i[WA_W-1:IW];
      end else if (beat) begin
        if (beat_err_i) begin
          err_q       <= 1'b1;
          buf_valid_q <= 1'b0;
        end
        if (beat_first) crit_pend_q <= 1'b0;
        if (beat_last)  fill_q      <= 1'b0;
      end
    end
  end

  assign cw_addr_o = {tag_q, {OFF{1'b0}}};

  assert_busy_miss_dropped_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q && miss_valid_i) |=> !bus_req_o)
    else $error("miss accepted during a fill");

  assert_write_full_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_en_o |-> (&arrived))
    else $error("cache write with missing words");

  assert_write_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_en_o |=> !cw_en_o)
    else $error("cache write longer than one cycle");

  assert_no_write_on_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_en_o |-> !err_q)
    else $error("cache written after a bus error");

  assert_err_kills_buffer_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && beat_err_i) |=> !buf_valid_q)
    else $error("buffer still valid after error");
endmodule

// File: tb/test_line_fill_buf.sv
`timescale 1ns/100ps
module test_line_fill_buf;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         miss_valid = 1'b0;
  logic [29:0]  miss_addr = '0;
  logic         bus_req;
  logic [31:0]  bus_addr;
  logic         beat_valid = 1'b0;
  logic [31:0]  beat_data = '0;
  logic         beat_err = 1'b0;
  logic         rd_req = 1'b0;
  logic [29:0]  rd_addr = '0;
  logic         rd_valid, rd_abort, rd_miss, cw_en;
  logic [31:0]  rd_data, cw_addr;
  logic [255:0] cw_data;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  line_fill_buf i_line_fill_buf (
    .clk_i(clk), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
    .bus_req_o(bus_req), .bus_addr_o(bus_addr),
    .beat_valid_i(beat_valid), .beat_data_i(beat_data), .beat_err_i(beat_err),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_abort_o(rd_abort), .rd_miss_o(rd_miss),
    .cw_en_o(cw_en), .cw_addr_o(cw_addr), .cw_data_o(cw_data)
  );

  task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // behavioural reference model
  bit          m_fill, m_cpend, m_bval, m_err;
  int          m_crit, m_cnt;
  logic [26:0] m_tag;
  logic [31:0] m_dat [8];
  bit          m_arr [8];
  bit          e_rv, e_ab, e_rm, e_br, e_cw, e_crit;
  logic [31:0] e_rd, e_ba, e_ca;
  logic [255:0] e_cd;
  string       rv_tag = "R6", rm_tag = "R8";
  bit          started = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_fill = 0; m_cpend = 0; m_bval = 0; m_err = 0; m_cnt = 0; m_crit = 0; m_tag = '0;
      foreach (m_arr[i]) begin m_arr[i] = 0; m_dat[i] = '0; end
      e_rv = 0; e_ab = 0; e_rm = 0; e_br = 0; e_cw = 0; e_crit = 0;
    end else begin
      bit busy, fill0, n_rv, n_ab, n_rm, n_cw, n_crit;
      logic [31:0] n_rd;
      busy = e_rv | e_rm;
      fill0 = m_fill;
      n_rv = 0; n_ab = 0; n_rm = 0; n_cw = 0; n_crit = 0; n_rd = e_rd;
      if (rd_req && !busy && !m_cpend) begin
        if (m_bval && rd_addr[29:3] == m_tag) begin
          if (m_arr[rd_addr[2:0]]) begin
            n_rv = 1; n_rd = m_dat[rd_addr[2:0]];
            rv_tag = m_fill ? "R6" : "R12";
          end
        end else if (!m_fill) begin
          n_rm = 1; rm_tag = m_err ? "R11" : "R8";
        end
      end
      if (beat_valid && m_fill) begin
        int w;
        w = (m_crit + m_cnt) % 8;
        m_dat[w] = beat_data; m_arr[w] = 1;
        if (beat_err) begin m_err = 1; m_bval = 0; end
        if (m_cnt == 0) begin
          n_rv = 1; n_rd = beat_data; n_ab = beat_err; n_crit = 1; m_cpend = 0;
        end
        if (m_cnt == 7) begin
          m_fill = 0; n_cw = !m_err;
          e_ca = {m_tag, 5'b0};
          for (int i = 0; i < 8; i++) e_cd[i*32 +: 32] = m_dat[i];
        end
        m_cnt++;
      end
      e_br = 0;
      if (miss_valid && !fill0) begin
        e_br = 1; e_ba = {miss_addr, 2'b00};
        m_fill = 1; m_cpend = 1; m_bval = 1; m_err = 0; m_cnt = 0;
        m_tag = miss_addr[29:3]; m_crit = int'(miss_addr[2:0]);
        foreach (m_arr[i]) m_arr[i] = 0;
      end
      e_rv = n_rv; e_ab = n_ab; e_rm = n_rm; e_cw = n_cw; e_crit = n_crit; e_rd = n_rd;
      started = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && started) begin
      check(e_rv ? (e_crit ? "R3" : rv_tag) : "R7", "rd_valid", 256'(rd_valid), 256'(e_rv));
      if (e_rv) check(e_crit ? "R3" : rv_tag, "rd_data", 256'(rd_data), 256'(e_rd));
      check(e_crit ? "R4" : "R5", "rd_abort", 256'(rd_abort), 256'(e_ab));
      check(rm_tag, "rd_miss", 256'(rd_miss), 256'(e_rm));
      check("R1", "bus_req", 256'(bus_req), 256'(e_br));
      if (e_br) check("R1", "bus_addr", 256'(bus_addr), 256'(e_ba));
      check(e_cw ? "R9" : (m_err ? "R10" : "R9"), "cw_en", 256'(cw_en), 256'(e_cw));
      if (e_cw) begin
        check("R9", "cw_addr", 256'(cw_addr), 256'(e_ca));
        check("R2", "cw_data", cw_data, e_cd);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  function automatic logic [31:0] wdat(logic [29:0] line_wa, int w);
    return {line_wa[15:0], 16'h0} ^ 32'h5A00_0000 ^ (32'(w) * 32'h0101_0101);
  endfunction

  task automatic start_miss(logic [29:0] wa);
    tick(); miss_valid = 1; miss_addr = wa;
    tick(); miss_valid = 0;
  endtask

  // wrapping beats from crit; err_k = beat number carrying an error (-1 none)
  task automatic send_line(logic [29:0] wa, int err_k, int gap);
    for (int k = 0; k < 8; k++) begin
      int w;
      w = (int'(wa[2:0]) + k) % 8;
      tick();
      beat_valid = 1; beat_data = wdat({wa[29:3], 3'b0}, w); beat_err = (k == err_k);
      for (int g = 0; g < gap; g++) begin tick(); beat_valid = 0; beat_err = 0; end
    end
    tick(); beat_valid = 0; beat_err = 0;
  endtask

  task automatic do_read(logic [29:0] wa);
    bit done;
    done = 0;
    tick(); rd_req = 1; rd_addr = wa;
    for (int i = 0; i < 200 && !done; i++) begin
      @(negedge clk);
      if (rd_valid || rd_miss) done = 1;
    end
    if (!done) begin
      errs++; checks++;
      $display("FAIL R7 read never answered: actual=none expected=response");
    end
    #1 rd_req = 0;
  endtask

  initial begin
    #(4 * 100000);
    errs++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", "rd_valid", 256'(rd_valid), 0);
    check("R13", "rd_miss", 256'(rd_miss), 0);
    check("R13", "rd_abort", 256'(rd_abort), 0);
    check("R13", "bus_req", 256'(bus_req), 0);
    check("R13", "cw_en", 256'(cw_en), 0);
    #1 rst_ni = 1;
    idle(2);
    do_read(30'h0000_0411);                 // R13 empty buffer -> miss

    // clean fill, critical index 5, back-to-back beats (R2, R3, R9)
    start_miss(30'h0000_0815);
    idle(2);
    send_line(30'h0000_0815, -1, 0);
    idle(2);
    do_read(30'h0000_0812);                 // R12 served after completion
    do_read(30'h0000_0900);                 // R8 other line, idle -> miss

    // critical index 0 with gaps: R6, R7, R8 stall, R1 busy miss ignored
    start_miss(30'h0000_0C00);
    fork
      send_line(30'h0000_0C00, -1, 3);
      begin
        idle(6);
        do_read(30'h0000_0C06);             // R7 not yet arrived
        do_read(30'h0000_0C01);             // R6 arrived
        do_read(30'h0000_1400);             // R8 foreign line stalls
      end
      begin
        idle(9);
        start_miss(30'h0000_1000);          // R1 ignored while filling
      end
    join
    idle(3);

    // error on a middle beat: R5 no abort, R10 no write, R11 no data
    start_miss(30'h0000_1802);
    fork
      send_line(30'h0000_1802, 3, 2);
      begin idle(14); do_read(30'h0000_1802); end
    join
    idle(3);
    do_read(30'h0000_1803);                 // R11 after fill -> miss

    // error on the critical beat: R4 abort, R10 no write
    start_miss(30'h0000_1C07);
    send_line(30'h0000_1C07, 0, 1);
    idle(3);

    // critical index 3, clean, then read back (R2, R12)
    start_miss(30'h0000_2003);
    send_line(30'h0000_2003, -1, 1);
    idle(2);
    do_read(30'h0000_2007);
    start_miss(30'h0000_2400);              // new miss replaces buffer
    fork
      send_line(30'h0000_2400, -1, 0);
      begin idle(12); do_read(30'h0000_2003); end
    join
    idle(4);
    finish_run();
  end
endmodule